// File: doc/BRIEF.md
# Rectangular Block Operation Engine

This engine carries out 2D operations on rectangular regions of 16-bit RGBA images that sit in a word-addressed external memory. The operation and its operands are captured on a start pulse: source and destination base addresses, the line pitch of each picture, the block width and height, a fill colour and an alpha value. The engine then walks the rectangle line by line, issuing one memory word per granted cycle on a shared bus. It supports copy, move (copy followed by erasing the source), fill, clear and alpha replacement.

The memory bus can be taken away at any cycle. When the grant drops, the engine keeps its request, address and data unchanged. Its horizontal and vertical progress counters hold still, so the operation continues exactly where it stopped once the grant returns. Copy and move stage each source line in an internal line buffer before writing it to the destination line.

States: IDLE waits for start. RD_LINE reads a source line into the buffer. WR_LINE writes the buffer to the destination line. FILL writes a constant colour. ALPHA_RD and ALPHA_WR read and rewrite one pixel at a time. ERASE blanks the source of a move. DONE gives the completion pulse.

Transitions:
- IDLE→RD_LINE on start for copy or move.
- IDLE→FILL on start for fill or clear.
- IDLE→ALPHA_RD on start for alpha.
- IDLE→DONE on start with zero size or an unknown code.
- RD_LINE→WR_LINE after the last pixel of the line.
- WR_LINE→RD_LINE after a line that is not the last.
- WR_LINE→ERASE (move) or WR_LINE→DONE (copy) after the last line.
- ALPHA_RD→ALPHA_WR on every granted read.
- ALPHA_WR→ALPHA_RD on every granted write except the last.
- ALPHA_WR→DONE after the last pixel.
- FILL→DONE and ERASE→DONE after the last pixel.
- DONE→IDLE always.

Top module: `blk_engine`

## Requirements
- R1: After reset, busy, done and mem_req are 0.
- R2: A start pulse in IDLE captures all operands and raises busy in the next cycle. A start pulse while busy is ignored and does not change the running operation.
- R3: The pixel at column h and row v of a rectangle is at word address base + h + v × pitch (modulo 2^AW). Rows are visited in ascending order, and columns in ascending order within a row.
- R4: Copy (op code 0) leaves every destination pixel equal to the corresponding source pixel, and leaves the source unchanged. The block width must not exceed BUF_DEPTH.
- R5: Move (op code 1) produces the copy result and then sets every source pixel to 16'h0000. No source word is erased before the last destination word has been written.
- R6: Fill (op code 2) writes the colour operand to every destination pixel. Words outside the rectangle are untouched.
- R7: Clear (op code 3) writes 16'h0000 to every destination pixel.
- R8: Alpha (op code 4) replaces bits [3:0] of each destination pixel with the alpha operand and keeps bits [15:4].
- R9: A word is transferred only in a cycle with mem_req and mem_gnt both high. While mem_gnt is low, mem_req, mem_we, mem_addr and mem_wdata hold their values, and the final memory content does not depend on the grant pattern.
- R10: A start with zero width, zero height or an op code above 4 gives done in the next cycle and makes no memory access. No access is ever made while busy is low.
- R11: done is a single-cycle pulse. busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken in IDLE only |
| op | input | 3 | 0 copy, 1 move, 2 fill, 3 clear, 4 alpha |
| src_base | input | AW | Source rectangle base address |
| src_pitch | input | CW | Source picture width in words |
| dst_base | input | AW | Destination rectangle base address |
| dst_pitch | input | CW | Destination picture width in words |
| blk_w | input | CW | Block width in pixels |
| blk_h | input | CW | Block height in lines |
| colour | input | DW | Fill colour |
| alpha_val | input | AL | Alpha value for alpha replacement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the granted read cycle |
| mem_gnt | input | 1 | Grant; low means the bus is preempted |

## Verification
The bench builds the engine with AW=10, CW=8 and BUF_DEPTH=8. This keeps the whole 1024-word memory small enough to compare in full after every operation. With these values, every operation is swept over all widths from 1 to the full line-buffer depth and heights from 1 to 3. Each combination runs once with a permanent grant and once with a pseudo-random grant that drops about a quarter of the cycles, which reaches preemption at line ends, between the read and write of an alpha pixel, and at the switch from copy to erase.

// File: rtl/blk_pkg.sv
package blk_pkg;

    typedef enum logic [2:0] {
        OP_COPY  = 3'd0,
        OP_MOVE  = 3'd1,
        OP_FILL  = 3'd2,
        OP_CLEAR = 3'd3,
        OP_ALPHA = 3'd4
    } blk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_LINE  = 3'd1,
        ST_WR_LINE  = 3'd2,
        ST_FILL     = 3'd3,
        ST_ALPHA_RD = 3'd4,
        ST_ALPHA_WR = 3'd5,
        ST_ERASE    = 3'd6,
        ST_DONE     = 3'd7
    } blk_state_e;

endpackage

// File: rtl/blk_linebuf.sv
module blk_linebuf #(
    parameter int DW    = 16,
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store[rd_idx];
endmodule

// File: rtl/blk_addr.sv
module blk_addr #(
    parameter int AW = 23,
    parameter int CW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] pitch,
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] row,
    output logic [AW-1:0] addr
);
    localparam int PW = 2 * CW;
    logic [PW-1:0] row_ofs;

    always_comb begin
        row_ofs = PW'(row) * PW'(pitch);
        addr    = base + AW'(col) + AW'(row_ofs);
    end
endmodule

// File: rtl/blk_engine.sv
module blk_engine #(
    parameter int AW        = 23,
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter int AL        = 4,
    parameter int BUF_DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [AW-1:0] src_base,
    input  logic [CW-1:0] src_pitch,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] dst_pitch,
    input  logic [CW-1:0] blk_w,
    input  logic [CW-1:0] blk_h,
    input  logic [DW-1:0] colour,
    input  logic [AL-1:0] alpha_val,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_gnt
);
    import blk_pkg::*;

    localparam int BW = $clog2(BUF_DEPTH);

    blk_state_e    state_q, state_d;
    logic [2:0]    op_q;
    logic [AW-1:0] src_base_q, dst_base_q;
    logic [CW-1:0] src_pitch_q, dst_pitch_q, w_q, h_q;
    logic [CW-1:0] hcnt, vcnt;
    logic [DW-1:0] fill_q, pix_q;
    logic [AL-1:0] alpha_q;
    logic          beat, last_h, last_v, adv_h, adv_v, use_src;
    logic [DW-1:0] buf_rd;
    logic [AW-1:0] sel_base;
    logic [CW-1:0] sel_pitch;

    assign beat   = mem_req && mem_gnt;
    assign last_h = (hcnt == w_q - CW'(1));
    assign last_v = (vcnt == h_q - CW'(1));
    assign adv_h  = beat && (state_q != ST_ALPHA_RD);
    assign adv_v  = adv_h && last_h && (state_q != ST_RD_LINE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (blk_w == '0 || blk_h == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        case (op)
                            OP_COPY, OP_MOVE:  state_d = ST_RD_LINE;
                            OP_FILL, OP_CLEAR: state_d = ST_FILL;
                            OP_ALPHA:          state_d = ST_ALPHA_RD;
                            default:           state_d = ST_DONE;
                        endcase
                    end
                end
            end
            ST_RD_LINE:  if (beat && last_h) state_d = ST_WR_LINE;
            ST_WR_LINE: begin
                if (beat && last_h) begin
                    if (!last_v)               state_d = ST_RD_LINE;
                    else if (op_q == OP_MOVE)  state_d = ST_ERASE;
                    else                       state_d = ST_DONE;
                end
            end
            ST_FILL:     if (beat && last_h && last_v) state_d = ST_DONE;
            ST_ALPHA_RD: if (beat) state_d = ST_ALPHA_WR;
            ST_ALPHA_WR: if (beat) state_d = (last_h && last_v) ? ST_DONE : ST_ALPHA_RD;
            ST_ERASE:    if (beat && last_h && last_v) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and progress counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                op_q        <= op;
                src_base_q  <= src_base;
                src_pitch_q <= src_pitch;
                dst_base_q  <= dst_base;
                dst_pitch_q <= dst_pitch;
                w_q         <= blk_w;
                h_q         <= blk_h;
                fill_q      <= (op == OP_CLEAR) ? '0 : colour;
                alpha_q     <= alpha_val;
                hcnt        <= '0;
                vcnt        <= '0;
            end
        end else begin
            if (adv_h) hcnt <= last_h ? '0 : hcnt + CW'(1);
            if (adv_v) vcnt <= last_v ? '0 : vcnt + CW'(1);
            if (beat && state_q == ST_ALPHA_RD) pix_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        use_src   = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_RD_LINE:  begin mem_req = 1'b1; use_src = 1'b1; end
            ST_WR_LINE:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = buf_rd; end
            ST_FILL:     begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = fill_q; end
            ST_ALPHA_RD: mem_req = 1'b1;
            ST_ALPHA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {pix_q[DW-1:AL], alpha_q};
            end
            ST_ERASE:    begin mem_req = 1'b1; mem_we = 1'b1; use_src = 1'b1; end
            ST_DONE:     begin busy = 1'b0; done = 1'b1; end
            default:     busy = 1'b0;
        endcase
    end

    assign sel_base  = use_src ? src_base_q  : dst_base_q;
    assign sel_pitch = use_src ? src_pitch_q : dst_pitch_q;

    blk_addr #(.AW(AW), .CW(CW)) u_addr (
        .base  (sel_base),
        .pitch (sel_pitch),
        .col   (hcnt),
        .row   (vcnt),
        .addr  (mem_addr)
    );

    blk_linebuf #(.DW(DW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (beat && state_q == ST_RD_LINE),
        .wr_idx  (hcnt[BW-1:0]),
        .wr_data (mem_rdata),
        .rd_idx  (hcnt[BW-1:0]),
        .rd_data (buf_rd)
    );
endmodule

// File: rtl/blk_engine_chk.sv
module blk_engine_chk #(
    parameter int AW = 23,
    parameter int DW = 16,
    parameter int AL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic [2:0]    state_q
);
    import blk_pkg::*;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                    // R11
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);                                                // R10
    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));                 // R9
    AST_ALPHA_RGB_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALPHA_WR && $past(mem_req && mem_gnt && !mem_we))
        |-> (mem_wdata[DW-1:AL] == $past(mem_rdata[DW-1:AL])
             && mem_addr == $past(mem_addr)));                              // R8
endmodule

bind blk_engine blk_engine_chk #(.AW(AW), .DW(DW), .AL(AL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .state_q   (state_q)
);

// File: tb/blk_engine_tb.sv
module blk_engine_tb;
    localparam int AW = 10, DW = 16, CW = 8, AL = 4, BUFD = 8;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_gnt = 1'b1;
    logic [2:0]    op = '0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic [CW-1:0] src_pitch = '0, dst_pitch = '0, blk_w = '0, blk_h = '0;
    logic [DW-1:0] colour = '0;
    logic [AL-1:0] alpha_val = '0;
    logic          busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [MSZ];
    logic [DW-1:0] expm [MSZ];
    logic          init_req = 1'b0;
    logic          preempt = 1'b0;
    logic [7:0]    lfsr = 8'h5b;

    int checks = 0, errors = 0;
    int wr_cnt = 0, dst_wr = 0, tot = 0;
    logic early_erase = 1'b0;
    int SB = 100, SP = 20, DB = 500, DP = 24;

    always #2 clk = ~clk;

    blk_engine #(.AW(AW), .DW(DW), .CW(CW), .AL(AL), .BUF_DEPTH(BUFD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_base(src_base), .src_pitch(src_pitch), .dst_base(dst_base), .dst_pitch(dst_pitch),
        .blk_w(blk_w), .blk_h(blk_h), .colour(colour), .alpha_val(alpha_val),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
    );

    function automatic logic [DW-1:0] pattern(int a);
        return DW'(a * 37 + 5) ^ 16'h5a00;
    endfunction

    function automatic bit in_rect(int a, int base, int pitch, int w, int h);
        int off;
        if (a < base) return 1'b0;
        off = a - base;
        return (off / pitch < h) && (off % pitch < w);
    endfunction

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < MSZ; i++) mem[i] <= pattern(i);
        end else if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
            if (in_rect(int'(mem_addr), DB, DP, int'(blk_w), int'(blk_h))) dst_wr <= dst_wr + 1;
            else if (in_rect(int'(mem_addr), SB, SP, int'(blk_w), int'(blk_h)) && dst_wr < tot)
                early_erase <= 1'b1;
        end
    end

    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt <= preempt ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic init_mem();
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
        for (int i = 0; i < MSZ; i++) expm[i] = pattern(i);
        wr_cnt = 0; dst_wr = 0; early_erase = 1'b0;
    endtask

    task automatic pulse_start(int o, int w, int h, logic [DW-1:0] c, logic [AL-1:0] a);
        @(negedge clk);
        op = 3'(o); blk_w = CW'(w); blk_h = CW'(h); colour = c; alpha_val = a;
        src_base = AW'(SB); src_pitch = CW'(SP); dst_base = AW'(DB); dst_pitch = CW'(DP);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int n;
        n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(done, req, "done seen", int'(done), 1);
        @(negedge clk);
        check(!done && !busy, "R11", "done single pulse", int'(done), 0);
    endtask

    task automatic compare_mem(string req);
        int bad, first;
        bad = 0; first = -1;
        for (int i = 0; i < MSZ; i++)
            if (mem[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, req, "memory", 0, 0);
        else check(1'b0, req, $sformatf("memory word %0d", first), int'(mem[first]), int'(expm[first]));
    endtask

    task automatic run_op(int o, int w, int h, bit pm);
        logic [DW-1:0] c;
        logic [AL-1:0] a;
        string req;
        c = DW'(16'hc3a0 + w * 16 + h);
        a = AL'(w + h);
        req = (o == 0) ? "R4" : (o == 1) ? "R5" : (o == 2) ? "R6" : (o == 3) ? "R7" : "R8";
        init_mem();
        tot = w * h;
        preempt = pm;
        for (int v = 0; v < h; v++)
            for (int x = 0; x < w; x++) begin
                int s, d;
                s = SB + x + v * SP;
                d = DB + x + v * DP;
                case (o)
                    0: expm[d] = pattern(s);
                    1: begin expm[d] = pattern(s); expm[s] = '0; end
                    2: expm[d] = c;
                    3: expm[d] = '0;
                    default: expm[d] = {pattern(d)[DW-1:AL], a};
                endcase
            end
        pulse_start(o, w, h, c, a);
        check(busy, "R2", "busy after start", int'(busy), 1);
        wait_done(req);
        preempt = 1'b0;
        compare_mem(pm ? {req, "/R9/R3"} : {req, "/R3"});
        if (o == 1) check(!early_erase, "R5", "erase before copy end", int'(early_erase), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R1", "reset outputs", int'({busy, done, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R1", "idle after reset", int'({busy, done, mem_req}), 0);

        // R10: zero sizes and unknown code
        init_mem();
        pulse_start(2, 0, 3, 16'hffff, 4'h1);
        check(done && !busy, "R10", "zero width done", int'(done), 1);
        @(negedge clk);
        pulse_start(0, 4, 0, 16'hffff, 4'h1);
        check(done && !busy, "R10", "zero height done", int'(done), 1);
        @(negedge clk);
        pulse_start(6, 4, 2, 16'hffff, 4'h1);
        check(done && !busy, "R10", "unknown op done", int'(done), 1);
        @(negedge clk);
        check(wr_cnt == 0, "R10", "no writes", wr_cnt, 0);
        compare_mem("R10");

        // R2: start while busy is ignored
        init_mem();
        tot = 8;
        for (int v = 0; v < 2; v++)
            for (int x = 0; x < 4; x++) expm[DB + x + v * DP] = 16'h1234;
        pulse_start(2, 4, 2, 16'h1234, 4'h0);
        pulse_start(2, 4, 2, 16'h9999, 4'h0);
        wait_done("R2");
        compare_mem("R2");

        // sweep of all operations, sizes and grant patterns
        for (int o = 0; o < 5; o++)
            for (int w = 1; w <= BUFD; w++)
                for (int h = 1; h <= 3; h++)
                    for (int pm = 0; pm < 2; pm++)
                        run_op(o, w, h, pm[0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule